// File: doc/BRIEF.md
# Infrared Carrier Modulator with Pin Select

This block derives a 38 kHz square-wave carrier from the system clock and combines it with a level that software writes to each pin. The result is a modulated line suitable for an infrared link, for example a serial transmit stream, or for driving an LED in short, low-power pulses. The carrier is mixed in by exclusive-OR. A pin driven to 0 therefore emits carrier bursts, and a pin driven to 1 emits the inverted carrier.

Two small registers control the block. The control register holds one global enable bit. The mask register holds one select bit per pin. A pin is modulated only when the global enable is set and that pin's mask bit is also set. Every other pin passes its level through, delayed by the output register. The system clock frequency and the carrier frequency are parameters, and the half period is derived from them at elaboration. While the global enable is low, the carrier divider is held at zero. This means each burst begins on a known phase.

Top module: `ircm_top`

## Requirements
- R1: While `rst_n` is low, `pin_out` is all zeros. Both registers read back as zero.
- R2: A write with `wr_sel`=0 sets the control register, and only data bit 0 (the global enable) is stored. A write with `wr_sel`=1 stores the pin mask, with bit i selecting pin i. `rd_data` shows the register chosen by `rd_sel`, using the same encoding, and all unstored bits read as 0.
- R3: While enabled, the carrier is a 50 % duty square wave. Each half lasts H = round(CLK_HZ / (2·CARRIER_HZ)) clock cycles, which is 1645 cycles at 125 MHz.
- R4: After the enabling write, the carrier is low for the first H cycles and then high for the next H cycles.
- R5: On a pin that is both selected and enabled, `pin_out` equals the level XOR the carrier.
- R6: On a pin whose mask bit is 0, `pin_out` equals its level, whatever the enable and carrier are doing.
- R7: While the global enable is 0, every pin passes its level through, whatever the mask holds.
- R8: Clearing the enable resets the carrier phase. The next enabling write starts again with a low half of H cycles.
- R9: `pin_out` is registered. It reflects the level and the carrier one clock edge after they were presented.

Top module parameters: `CLK_HZ`, `CARRIER_HZ`, `NUM_PINS`, `DATA_W`, `REGISTER_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 mask |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 mask |
| rd_data | output | DATA_W | Read data of the selected register |
| level_in | input | NUM_PINS | Level written for each pin |
| pin_out | output | NUM_PINS | Modulated or passed-through pin levels |

## Verification
Three kinds of level stream are driven while the output is compared every cycle over several full carrier periods. A constant all-zero or all-one stream exposes the carrier shape, its half period and its starting phase. A stream that counts up every cycle exposes the one-cycle output latency. A scrambled stream tells apart selected pins from unselected ones under mixed masks. The same sweeps are repeated with the enable cleared and with an empty mask, which separates the gating by enable from the gating by mask. A sweep that is cut off mid-burst and then restarted shows that the phase resets.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

   typedef enum logic {
      REG_CTRL = 1'b0,
      REG_MASK = 1'b1
   } ircm_reg_e;

   localparam int CTRL_EN_BIT = 0;

   function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                               input int unsigned car_hz);
      return (clk_hz + car_hz) / (2 * car_hz);
   endfunction

endpackage

// File: rtl/ircm_regs.sv
module ircm_regs
   import ircm_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              en_q,
   output logic [NUM_PINS-1:0] mask_q
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_width
         $error("ircm_regs: NUM_PINS must be in 1..DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (ircm_reg_e'(wr_sel) == REG_CTRL)
            en_q <= wr_data[CTRL_EN_BIT];
         else
            mask_q <= wr_data[NUM_PINS-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (ircm_reg_e'(rd_sel) == REG_CTRL)
         rd_data[CTRL_EN_BIT] = en_q;
      else
         rd_data[NUM_PINS-1:0] = mask_q;
   end

endmodule

// File: rtl/ircm_carrier.sv
module ircm_carrier #(
   parameter int unsigned HALF = 1645
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic carrier
);

   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("ircm_carrier: half period must be at least one cycle");
      end

      if (HALF == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      carrier <= 1'b0;
            else if (!run)   carrier <= 1'b0;
            else             carrier <= ~carrier;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt     <= '0;
               carrier <= 1'b0;
            end else if (!run) begin
               cnt     <= '0;
               carrier <= 1'b0;
            end else if (cnt == CW'(HALF - 1)) begin
               cnt     <= '0;
               carrier <= ~carrier;
            end else begin
               cnt     <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ircm_mixer.sv
module ircm_mixer #(
   parameter int unsigned NUM_PINS     = 8,
   parameter bit          REGISTER_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                carrier,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] level,
   output logic [NUM_PINS-1:0] pin_out
);

   genvar i;
   generate
      for (i = 0; i < NUM_PINS; i++) begin : g_pin
         logic mixed;
         assign mixed = level[i] ^ (en & mask[i] & carrier);

         if (REGISTER_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pin_out[i] <= 1'b0;
               else        pin_out[i] <= mixed;
            end
         end else begin : g_comb
            assign pin_out[i] = mixed;
         end
      end
   endgenerate

endmodule

// File: rtl/ircm_top.sv
module ircm_top
   import ircm_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned CARRIER_HZ   = 38_000,
   parameter int unsigned NUM_PINS     = 8,
   parameter int unsigned DATA_W       = 8,
   parameter bit          REGISTER_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                rd_sel,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_PINS-1:0] level_in,
   output logic [NUM_PINS-1:0] pin_out
);

   localparam int unsigned HALF_CYC = half_cycles(CLK_HZ, CARRIER_HZ);

   generate
      if (CARRIER_HZ == 0 || CLK_HZ < 2 * CARRIER_HZ) begin : g_bad_freq
         $error("ircm_top: clock must be at least twice the carrier");
      end
   endgenerate

   logic                en_q;
   logic [NUM_PINS-1:0] mask_q;
   logic                carrier;

   ircm_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .en_q    (en_q),
      .mask_q  (mask_q)
   );

   ircm_carrier #(
      .HALF (HALF_CYC)
   ) i_carrier (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .carrier (carrier)
   );

   ircm_mixer #(
      .NUM_PINS     (NUM_PINS),
      .REGISTER_OUT (REGISTER_OUT)
   ) i_mixer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .carrier (carrier),
      .mask    (mask_q),
      .level   (level_in),
      .pin_out (pin_out)
   );

endmodule

// File: rtl/ircm_checker.sv
module ircm_checker #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HALF     = 1645
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_sel,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] level_in,
   input logic [NUM_PINS-1:0] pin_out,
   input logic                en_q,
   input logic [NUM_PINS-1:0] mask_q,
   input logic                carrier
);

   logic [31:0] run_len;
   logic        car_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         car_d   <= 1'b0;
      end else begin
         car_d <= carrier;
         if (!en_q || carrier != car_d) run_len <= '0;
         else                           run_len <= run_len + 1;
      end
   end

   // R2
   ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 1'b0) |-> (rd_data[DATA_W-1:1] == '0));

   // R3
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= HALF);

   // R4
   first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> !carrier);

   // R6
   unselected_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pin_out ^ $past(level_in)) & ~$past(mask_q)) == '0));

   // R7
   disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (pin_out == $past(level_in)));

   // R8
   idle_carrier_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !carrier);

endmodule

bind ircm_top ircm_checker #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .HALF     (HALF_CYC)
) i_ircm_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_sel   (rd_sel),
   .rd_data  (rd_data),
   .level_in (level_in),
   .pin_out  (pin_out),
   .en_q     (en_q),
   .mask_q   (mask_q),
   .carrier  (carrier)
);

// File: tb/test_ircm_top.sv
module test_ircm_top;

   localparam int H       = $rtoi(125.0e6 / 76000.0 + 0.5);
   localparam int WD_MAX  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] level_in = '0;
   logic [7:0] pin_out;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ircm_top #(
      .CLK_HZ       (125_000_000),
      .CARRIER_HZ   (38_000),
      .NUM_PINS     (8),
      .DATA_W       (8),
      .REGISTER_OUT (1'b1)
   ) i_ircm_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .level_in (level_in),
      .pin_out  (pin_out)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_MAX && !done) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD_MAX);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] data);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int p, input int n);
      case (p)
         0:       return 8'h00;
         1:       return 8'hFF;
         2:       return n[7:0];
         default: return 8'hA5 ^ 8'(n * 37);
      endcase
   endfunction

   // Restart: clear enable, set mask, write enable; then compare each cycle.
   task automatic sweep(input logic [7:0] mask, input logic en_on,
                        input int p, input int ncyc, input string req);
      wr(1'b0, 8'h00);
      wr(1'b1, mask);
      wr(1'b0, {7'b0, en_on});
      for (int n = 1; n <= ncyc; n++) begin
         logic car;
         level_in = pat(p, n);
         @(posedge clk);
         @(negedge clk);
         car = en_on && ((((n - 1) / H) % 2) == 1);
         chk(req, pin_out, pat(p, n) ^ (car ? mask : 8'h00));
      end
   endtask

   initial begin
      level_in = 8'h3C;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pin_out", pin_out, 8'h00);
      rd_sel = 1'b0;
      #1 chk("R1 ctrl", rd_data, 8'h00);
      rd_sel = 1'b1;
      #1 chk("R1 mask", rd_data, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 register encoding
      wr(1'b0, 8'hFE);
      rd_sel = 1'b0; #1 chk("R2 ctrl bit0 only", rd_data, 8'h00);
      wr(1'b0, 8'hFF);
      #1 chk("R2 ctrl enable", rd_data, 8'h01);
      wr(1'b1, 8'h96);
      rd_sel = 1'b1; #1 chk("R2 mask", rd_data, 8'h96);
      rd_sel = 1'b0; #1 chk("R2 ctrl kept", rd_data, 8'h01);

      // R3 R4 R5: all pins, level 0, carrier shape and phase
      sweep(8'hFF, 1'b1, 0, 3 * H + 5, "R3/R4/R5 level0");
      // R5: level 1 inverts carrier
      sweep(8'hFF, 1'b1, 1, 2 * H + 5, "R5 level1");
      // R9: level changes every cycle, one-cycle latency
      sweep(8'h5A, 1'b1, 2, 2 * H + 5, "R9/R6 count");
      // R6: mixed masks
      sweep(8'h81, 1'b1, 3, 2 * H + 5, "R6 mixed");
      sweep(8'h00, 1'b1, 3, H + 5, "R6 empty mask");
      // R7: enable off, full mask
      sweep(8'hFF, 1'b0, 3, H + 5, "R7 disabled");
      // R8: cut mid-burst, restart starts low
      sweep(8'hFF, 1'b1, 0, H + H / 2, "R8 first run");
      sweep(8'hFF, 1'b1, 0, 2 * H + 5, "R8 restart");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule